// File: doc/BRIEF.md
# Geometry Primitive Emitter

This block sits after a geometry-stage shader and gathers the vertices the shader produces into a three-slot triangle buffer. On every emit command the shader offers sixteen four-component output registers. A stored 16-bit output mask selects the registers that matter, and those are packed densely, lowest register first, into an attribute list. The list is written into the buffer slot named by the command's vertex index.

When a command also carries the primitive flag, the block releases the whole triangle downstream once the new vertex is stored. It can first pulse a winding-change strobe, and then it presents slots 0, 1 and 2 in turn over a valid/ready handshake. While a release is in progress the block reports busy and refuses further emit commands. A configuration write loads the output mask, which stays in force for every later emit.

Top module: `geo_emitter`

## Requirements
- R1: After synchronous reset, `busy`, `err_idx`, `wind_strobe` and `vtx_valid` are low and the stored mask is zero. Buffer contents are undefined until they are written.
- R2: On an accepted emit with a valid index, the register at the k-th lowest set bit of the stored mask (k counted from 0) is written to attribute position k of the selected slot. Attribute position p occupies bits [p*ATTR_W +: ATTR_W] of `vtx_data`, and register r occupies the same range of `emit_regs`.
- R3: Attribute positions at or above the number of set mask bits keep their previous contents, and a zero mask leaves the slot unchanged.
- R4: `emit_vidx` values 0 to 2 select the slot that is overwritten. The other two slots are unchanged.
- R5: A cycle with `cfg_we` high loads `cfg_mask`, which applies to all later emits. An emit in that same cycle still uses the previous mask.
- R6: An accepted emit with `emit_prim` high and no winding flag raises `vtx_valid` in the next cycle with `vtx_slot` = 0. Slots 1 and 2 follow, each after a handshake. The released triangle already holds the vertex of that command.
- R7: With `emit_prim` and `emit_wind` both high, `wind_strobe` is high for exactly the one cycle after acceptance, and `vtx_valid` rises in the cycle after the strobe.
- R8: An emit with `emit_vidx` = 3 writes nothing and releases nothing, even if `emit_prim` is set. `err_idx` is high for the following cycle.
- R9: `busy` is high from the cycle after a releasing emit until the cycle after slot 2 is accepted. An emit is accepted only when `emit_valid` is high and `busy` is low, and a refused emit has no effect.
- R10: While `vtx_valid` is high and `vtx_ready` is low, `vtx_valid`, `vtx_slot` and `vtx_data` hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Load the output mask |
| cfg_mask | input | NREG | New output mask |
| emit_valid | input | 1 | Emit command present |
| emit_vidx | input | 2 | Target buffer slot (3 is invalid) |
| emit_prim | input | 1 | Release the triangle after storing |
| emit_wind | input | 1 | Pulse the winding strobe before the release |
| emit_regs | input | NREG*NCOMP*COMP_W | The shader's output registers, register r at r*ATTR_W |
| busy | output | 1 | Release in progress, emits refused |
| err_idx | output | 1 | One-cycle pulse after an emit with index 3 |
| wind_strobe | output | 1 | One-cycle winding-change pulse |
| vtx_valid | output | 1 | Downstream vertex valid |
| vtx_ready | input | 1 | Downstream accepts the vertex |
| vtx_slot | output | 2 | Slot being presented |
| vtx_data | output | NREG*NCOMP*COMP_W | Attribute list of the presented slot |

## Verification
The bench goes after sparse masks, whose gaps must close up: a design that packed by register number instead of rank would put data at the wrong positions and expose stale positions. It also covers a zero mask and a mask changed in the same cycle as an emit, where a design using the new mask too early would store the wrong registers. Index 3 with the primitive flag set is driven to catch a design that writes a slot or starts a release anyway. Emits issued while a stalled release holds busy would corrupt the streamed triangle if they were not refused. Random back-pressure checks that slot order, data hold and the strobe-before-vertex timing survive stalls.

// File: rtl/geo_emit_pkg.sv
package geo_emit_pkg;
  // the triangle buffer depth is fixed by the primitive type
  localparam int unsigned SLOTS = 3;
  localparam int unsigned IDX_W = 2;

  typedef enum logic [1:0] {
    REL_IDLE = 2'd0,
    REL_WIND = 2'd1,
    REL_SEND = 2'd2
  } rel_state_e;
endpackage

// File: rtl/geo_compact.sv
// Packs the mask-selected registers densely, lowest register first.
module geo_compact #(
  parameter int unsigned NREG   = 16,
  parameter int unsigned ATTR_W = 96
) (
  input  logic [NREG-1:0]        mask,
  input  logic [NREG*ATTR_W-1:0] regs_in,
  output logic [NREG*ATTR_W-1:0] pk_out,
  output logic [NREG-1:0]        pos_en
);
  localparam int unsigned CNT_W = $clog2(NREG + 1);

  // rank[r] = number of selected registers below r
  logic [CNT_W-1:0] rank [NREG+1];

  always_comb begin
    logic [CNT_W-1:0] acc;
    acc = '0;
    for (int r = 0; r < NREG; r++) begin
      rank[r] = acc;
      acc = acc + CNT_W'(mask[r]);
    end
    rank[NREG] = acc;
  end

  generate
    for (genvar p = 0; p < NREG; p++) begin : g_pos
      logic [ATTR_W-1:0] pick;
      always_comb begin
        pick = '0;
        for (int r = 0; r < NREG; r++) begin
          if (mask[r] && (rank[r] == CNT_W'(p)))
            pick = regs_in[r*ATTR_W +: ATTR_W];
        end
      end
      assign pk_out[p*ATTR_W +: ATTR_W] = pick;
      assign pos_en[p] = (rank[NREG] > CNT_W'(p));
    end
  endgenerate
endmodule

// File: rtl/geo_vbuf.sv
// Three-slot vertex store, one small distributed RAM per attribute position.
module geo_vbuf
  import geo_emit_pkg::*;
#(
  parameter int unsigned NREG   = 16,
  parameter int unsigned ATTR_W = 96
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   wr_en,
  input  logic [IDX_W-1:0]       wr_slot,
  input  logic [NREG-1:0]        wr_pos_en,
  input  logic [NREG*ATTR_W-1:0] wr_data,
  input  logic [IDX_W-1:0]       rd_slot,
  output logic [NREG*ATTR_W-1:0] rd_data
);
  generate
    for (genvar p = 0; p < NREG; p++) begin : g_col
      logic [ATTR_W-1:0] col [SLOTS];
      always_ff @(posedge clk) begin
        if (wr_en && wr_pos_en[p] && (wr_slot < IDX_W'(SLOTS)))
          col[wr_slot] <= wr_data[p*ATTR_W +: ATTR_W];
      end
      assign rd_data[p*ATTR_W +: ATTR_W] = col[rd_slot];
    end
  endgenerate

  // R8: the control path never hands an out-of-range slot to the store
  assert_wr_slot_in_range_R8: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> (wr_slot < IDX_W'(SLOTS)));
  // R10: the presented slot never points outside the store
  assert_rd_slot_in_range_R10: assert property (@(posedge clk) disable iff (rst)
    rd_slot != 2'd3);
endmodule

// File: rtl/geo_release.sv
// Sequences the optional winding strobe and the three-vertex release.
module geo_release
  import geo_emit_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             start_wind,
  input  logic             out_ready,
  output logic             busy,
  output logic             wind_strobe,
  output logic             out_valid,
  output logic [IDX_W-1:0] out_slot
);
  localparam logic [IDX_W-1:0] LAST_SLOT = IDX_W'(SLOTS - 1);

  rel_state_e state;

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= REL_IDLE;
      busy        <= 1'b0;
      wind_strobe <= 1'b0;
      out_valid   <= 1'b0;
      out_slot    <= '0;
    end else begin
      unique case (state)
        REL_IDLE: begin
          if (start) begin
            busy     <= 1'b1;
            out_slot <= '0;
            if (start_wind) begin
              wind_strobe <= 1'b1;
              state       <= REL_WIND;
            end else begin
              out_valid <= 1'b1;
              state     <= REL_SEND;
            end
          end
        end
        REL_WIND: begin
          wind_strobe <= 1'b0;
          out_valid   <= 1'b1;
          state       <= REL_SEND;
        end
        REL_SEND: begin
          if (out_ready) begin
            if (out_slot == LAST_SLOT) begin
              out_valid <= 1'b0;
              busy      <= 1'b0;
              state     <= REL_IDLE;
            end else begin
              out_slot <= out_slot + 1'b1;
            end
          end
        end
        default: state <= REL_IDLE;
      endcase
    end
  end

  // R6: a release without winding presents slot 0 straight away
  assert_start_slot0_R6: assert property (@(posedge clk) disable iff (rst)
    (start && !busy && !start_wind) |=> (out_valid && out_slot == '0));
  // R6: slots advance by one on each handshake
  assert_slot_order_R6: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_ready && out_slot != LAST_SLOT) |=>
      (out_valid && out_slot == $past(out_slot) + 1'b1));
  // R7: the strobe lasts one cycle and is followed by slot 0
  assert_strobe_then_vertex_R7: assert property (@(posedge clk) disable iff (rst)
    wind_strobe |=> (!wind_strobe && out_valid && out_slot == '0));
  // R9: a vertex is only ever presented while busy
  assert_valid_inside_busy_R9: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> busy);
  // R10: a stalled vertex holds
  assert_hold_stall_R10: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_slot)));
endmodule

// File: rtl/geo_emitter.sv
module geo_emitter
  import geo_emit_pkg::*;
#(
  parameter int unsigned NREG   = 16,
  parameter int unsigned NCOMP  = 4,
  parameter int unsigned COMP_W = 24
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              cfg_we,
  input  logic [NREG-1:0]                   cfg_mask,
  input  logic                              emit_valid,
  input  logic [1:0]                        emit_vidx,
  input  logic                              emit_prim,
  input  logic                              emit_wind,
  input  logic [NREG*NCOMP*COMP_W-1:0]      emit_regs,
  output logic                              busy,
  output logic                              err_idx,
  output logic                              wind_strobe,
  output logic                              vtx_valid,
  input  logic                              vtx_ready,
  output logic [1:0]                        vtx_slot,
  output logic [NREG*NCOMP*COMP_W-1:0]      vtx_data
);
  localparam int unsigned ATTR_W = NCOMP * COMP_W;
  localparam int unsigned BUS_W  = NREG * ATTR_W;

  logic [NREG-1:0]  mask_q;
  logic             accept;
  logic             idx_ok;
  logic             do_write;
  logic             do_start;
  logic [BUS_W-1:0] pk_data;
  logic [NREG-1:0]  pk_en;

  assign accept   = emit_valid && !busy;
  assign idx_ok   = (emit_vidx < IDX_W'(SLOTS));
  assign do_write = accept && idx_ok;
  assign do_start = do_write && emit_prim;

  // mask register: an emit in the load cycle sees the old value
  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q  <= '0;
      err_idx <= 1'b0;
    end else begin
      if (cfg_we)
        mask_q <= cfg_mask;
      err_idx <= accept && !idx_ok;
    end
  end

  geo_compact #(.NREG(NREG), .ATTR_W(ATTR_W)) u_compact (
    .mask    (mask_q),
    .regs_in (emit_regs),
    .pk_out  (pk_data),
    .pos_en  (pk_en)
  );

  geo_vbuf #(.NREG(NREG), .ATTR_W(ATTR_W)) u_vbuf (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (do_write),
    .wr_slot   (emit_vidx),
    .wr_pos_en (pk_en),
    .wr_data   (pk_data),
    .rd_slot   (vtx_slot),
    .rd_data   (vtx_data)
  );

  geo_release u_release (
    .clk         (clk),
    .rst         (rst),
    .start       (do_start),
    .start_wind  (emit_wind),
    .out_ready   (vtx_ready),
    .busy        (busy),
    .wind_strobe (wind_strobe),
    .out_valid   (vtx_valid),
    .out_slot    (vtx_slot)
  );

  // R8: an invalid index reports an error in the next cycle
  assert_bad_idx_flag_R8: assert property (@(posedge clk) disable iff (rst)
    (emit_valid && !busy && emit_vidx == 2'd3) |=> err_idx);
  // R8: an invalid index never starts a release
  assert_bad_idx_no_release_R8: assert property (@(posedge clk) disable iff (rst)
    (emit_valid && !busy && emit_vidx == 2'd3) |=> (!busy && !vtx_valid && !wind_strobe));
  // R10: stalled vertex data holds while the buffer is locked
  assert_data_hold_R10: assert property (@(posedge clk) disable iff (rst)
    (vtx_valid && !vtx_ready) |=> $stable(vtx_data));
endmodule

// File: tb/sim_geo_emitter.sv
module sim_geo_emitter;
  localparam int unsigned NREG   = 16;
  localparam int unsigned NCOMP  = 4;
  localparam int unsigned COMP_W = 24;
  localparam int unsigned ATTR_W = NCOMP * COMP_W;
  localparam int unsigned BUS_W  = NREG * ATTR_W;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             cfg_we = 1'b0;
  logic [NREG-1:0]  cfg_mask = '0;
  logic             emit_valid = 1'b0;
  logic [1:0]       emit_vidx = '0;
  logic             emit_prim = 1'b0;
  logic             emit_wind = 1'b0;
  logic [BUS_W-1:0] emit_regs = '0;
  logic             busy, err_idx, wind_strobe, vtx_valid;
  logic             vtx_ready = 1'b1;
  logic [1:0]       vtx_slot;
  logic [BUS_W-1:0] vtx_data;

  int total = 0;
  int bad   = 0;
  int rdy_mode = 0;   // 0: always ready, 1: random, 2: stalled
  bit finished = 0;

  always #5 clk = ~clk;

  geo_emitter #(.NREG(NREG), .NCOMP(NCOMP), .COMP_W(COMP_W)) u0 (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_mask(cfg_mask),
    .emit_valid(emit_valid), .emit_vidx(emit_vidx), .emit_prim(emit_prim),
    .emit_wind(emit_wind), .emit_regs(emit_regs), .busy(busy),
    .err_idx(err_idx), .wind_strobe(wind_strobe), .vtx_valid(vtx_valid),
    .vtx_ready(vtx_ready), .vtx_slot(vtx_slot), .vtx_data(vtx_data)
  );

  // ---------------- behavioural reference model ----------------
  logic [ATTR_W-1:0] m_buf [3][NREG];
  bit        m_busy, m_valid, m_wind, m_err, m_acc;
  int        m_slot;
  logic [NREG-1:0] m_mask;

  always @(posedge clk) begin
    if (rst) begin
      m_busy = 0; m_valid = 0; m_wind = 0; m_err = 0; m_slot = 0; m_mask = '0;
    end else begin
      m_acc = emit_valid && !m_busy;
      m_err = m_acc && (emit_vidx == 2'd3);
      if (m_wind) begin
        m_wind = 0; m_valid = 1; m_slot = 0;
      end else if (m_valid && vtx_ready) begin
        if (m_slot == 2) begin m_valid = 0; m_busy = 0; end
        else m_slot = m_slot + 1;
      end
      if (m_acc && emit_vidx != 2'd3) begin
        int k;
        k = 0;
        for (int r = 0; r < NREG; r++) begin
          if (m_mask[r]) begin
            m_buf[emit_vidx][k] = emit_regs[r*ATTR_W +: ATTR_W];
            k = k + 1;
          end
        end
        if (emit_prim) begin
          m_busy = 1;
          if (emit_wind) m_wind = 1;
          else begin m_valid = 1; m_slot = 0; end
        end
      end
      if (cfg_we) m_mask = cfg_mask;
    end
  end

  function automatic logic [BUS_W-1:0] model_vertex(int s);
    logic [BUS_W-1:0] v;
    for (int p = 0; p < NREG; p++) v[p*ATTR_W +: ATTR_W] = m_buf[s][p];
    return v;
  endfunction

  task automatic chk(string req, logic [BUS_W-1:0] act, logic [BUS_W-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s at %0t: actual=%0h expected=%0h", req, $time, act, exp);
    end
  endtask

  // compare on every clock, away from the active edge
  always @(negedge clk) begin
    if (!finished) begin
      if (rst) begin
        chk("R1 busy", BUS_W'(busy), '0);
        chk("R1 vtx_valid", BUS_W'(vtx_valid), '0);
      end else begin
        chk("R9 busy", BUS_W'(busy), BUS_W'(m_busy));
        chk("R7 wind_strobe", BUS_W'(wind_strobe), BUS_W'(m_wind));
        chk("R6 vtx_valid", BUS_W'(vtx_valid), BUS_W'(m_valid));
        chk("R8 err_idx", BUS_W'(err_idx), BUS_W'(m_err));
        if (m_valid) begin
          chk("R6 R10 vtx_slot", BUS_W'(vtx_slot), BUS_W'(m_slot));
          chk("R2 R3 R4 R5 vtx_data", vtx_data, model_vertex(m_slot));
        end
      end
    end
  end

  // downstream ready driver
  always @(negedge clk) begin
    case (rdy_mode)
      0: vtx_ready <= 1'b1;
      1: vtx_ready <= 1'($urandom % 2);
      default: vtx_ready <= 1'b0;
    endcase
  end

  // ---------------- stimulus helpers ----------------
  function automatic logic [BUS_W-1:0] rand_bus();
    logic [BUS_W-1:0] b;
    for (int i = 0; i < BUS_W / 32; i++) b[i*32 +: 32] = $urandom;
    return b;
  endfunction

  task automatic wait_idle();
    @(negedge clk);
    while (busy) @(negedge clk);
  endtask

  task automatic set_mask(logic [NREG-1:0] m);
    @(negedge clk);
    cfg_we = 1'b1; cfg_mask = m;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic emit(logic [1:0] idx, bit prim, bit wind);
    @(negedge clk);
    emit_valid = 1'b1; emit_vidx = idx; emit_prim = prim; emit_wind = wind;
    emit_regs = rand_bus();
    @(negedge clk);
    emit_valid = 1'b0; emit_prim = 1'b0; emit_wind = 1'b0;
  endtask

  task automatic summary();
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL R9 watchdog expired: actual=busy expected=idle");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state observed at the ports
    chk("R1 err_idx", BUS_W'(err_idx), '0);
    chk("R1 wind_strobe", BUS_W'(wind_strobe), '0);
    rst = 1'b0;

    // fill every slot fully so later partial writes are observable
    set_mask('1);
    emit(2'd0, 0, 0); emit(2'd1, 0, 0); emit(2'd2, 0, 0);

    // R2 R3 R6: sparse mask, release without winding, slot 1 rewritten
    set_mask(16'h0005);
    emit(2'd1, 1, 0);
    wait_idle();

    // R8: index 3 with the primitive flag is rejected
    set_mask(16'h8001);
    emit(2'd3, 1, 1);
    emit(2'd0, 1, 0);
    wait_idle();

    // R7 R9 R10: winding release stalled, emits during busy are refused
    set_mask(16'hFFFF);
    rdy_mode = 2;
    emit(2'd2, 1, 1);
    emit(2'd0, 1, 0);
    emit(2'd1, 0, 0);
    repeat (5) @(negedge clk);
    rdy_mode = 1;
    wait_idle();

    // R3: zero mask leaves the slot intact
    set_mask('0);
    emit(2'd0, 1, 0);
    wait_idle();

    // R5: mask load in the same cycle as an emit applies afterwards only
    set_mask(16'h00F0);
    @(negedge clk);
    cfg_we = 1'b1; cfg_mask = 16'h0F0F;
    emit_valid = 1'b1; emit_vidx = 2'd2; emit_prim = 1'b1; emit_wind = 1'b0;
    emit_regs = rand_bus();
    @(negedge clk);
    cfg_we = 1'b0; emit_valid = 1'b0; emit_prim = 1'b0;
    wait_idle();
    emit(2'd1, 1, 1);
    wait_idle();

    // R4 R6 R9: random traffic with back-pressure
    rdy_mode = 1;
    for (int i = 0; i < 600; i++) begin
      @(negedge clk);
      cfg_we     = (($urandom % 8) == 0);
      cfg_mask   = NREG'($urandom);
      emit_valid = 1'($urandom % 2);
      emit_vidx  = 2'($urandom % 4);
      emit_prim  = 1'($urandom % 2);
      emit_wind  = 1'($urandom % 2);
      emit_regs  = rand_bus();
    end
    @(negedge clk);
    cfg_we = 1'b0; emit_valid = 1'b0;
    rdy_mode = 0;
    wait_idle();
    repeat (2) @(negedge clk);
    summary();
  end
endmodule